// File: doc/BRIEF.md
# Streaming Write Byte Tally with Length Cutoff

This block follows one streaming-to-memory transfer at a time. A one-cycle start pulse arms it with a 32-bit descriptor length and a flag that says whether the incoming packet's end marker should close the transfer. From then on it watches the data stream's handshake and framing sideband: valid, start of packet, end of packet, the count of unused bytes in the last beat, and an 8-bit error field. It totals the bytes that arrive from the start-of-packet beat onward and keeps a sticky record of every error bit it sees.

When the transfer closes, the block loads a completion record and raises its done bit for one cycle. A transfer closes in one of three ways. The packet can end within the length. The length can run out before the packet ends, which is an early termination. With the end marker disabled, the byte total can reach the length. After an early termination, the rest of the packet is absorbed silently up to its end marker. Address generation, bursts and strides belong to a neighbouring write engine and are not part of this block.

Top module: `xbt_byte_tally`

## Requirements
- R1: While reset is high, and right after it, the completion record `rec_o` is all zeros.
- R2: In end-on-packet mode, counting starts at the first valid beat with SOP. Valid beats before it are ignored, along with their error bits. Each counted beat without EOP adds BEAT_BYTES, and the EOP beat adds BEAT_BYTES minus `st_empty_i`. The record for a beat accepted at clock edge k is visible after edge k.
- R3: The done bit `rec_o[43]` is high for exactly one cycle per completed transfer. All other record bits hold their value until the next completion.
- R4: The error field is the bitwise OR of `st_error_i` over every beat taken into the transfer, including the beat that closes it.
- R5: In end-on-packet mode, a beat whose bytes would push the total past the length closes the transfer at once. That beat is not counted, so the count reports the total before it, and the early-termination bit `rec_o[42]` is set. Its error bits are still included.
- R6: After an early termination that is not on an EOP beat, valid beats are dropped up to and including the next EOP. They produce no further record, and beats that arrive without a new start are ignored.
- R7: With end-on-packet disabled, EOP does not close the transfer. The transfer completes on the beat where the total reaches or passes the length, and it reports exactly the length with the early-termination bit clear.
- R8: With end-on-packet disabled and a length of zero, the record appears after the second clock edge following the start pulse. It reports zero bytes, no errors, and done high.
- R9: A start pulse clears the byte total and the error accumulator and restarts the transfer, even in the middle of one. A beat presented in the same cycle as a start pulse is ignored.
- R10: Record layout: bits 31:0 hold the byte count, bits 33:32 are zero, bits 41:34 hold the errors, bit 42 is early termination and bit 43 is done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse that arms a new transfer |
| start_len_i | input | 32 | Descriptor length in bytes, taken with start_i |
| start_eop_en_i | input | 1 | 1: the packet end marker closes the transfer; 0: the length alone closes it |
| st_valid_i | input | 1 | Stream beat valid |
| st_sop_i | input | 1 | Beat is the first of a packet |
| st_eop_i | input | 1 | Beat is the last of a packet |
| st_empty_i | input | EMPTY_W (2) | Unused bytes in the EOP beat |
| st_error_i | input | 8 | Error sideband of the beat |
| rec_o | output | 44 | Completion record (see R10) |

## Verification
A vector table drives whole transfers: packets that end well inside the length, a packet that fills the length exactly (the boundary between normal end and cutoff), cutoffs in the middle of a packet and on a single-beat packet with zero length, and a long packet. The same table runs transfers in length-only mode whose last beat lands exactly on the length or past it, which shows saturation apart from plain counting. Directed cases then cover beats ahead of SOP, errors spread over several beats, EOP inside a length-only transfer, a zero-length length-only transfer, beats left over after a cutoff, and a restart in the middle of a transfer that coincides with a beat. Each of these separates a dropped or ignored beat from one that was counted.

// File: rtl/xbt_pkg.sv
`timescale 1ns/1ps
package xbt_pkg;
  localparam int LEN_W = 32;
  localparam int ERR_W = 8;
  localparam int REC_W = 44;
  localparam int CNT_W = LEN_W + 1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_COUNT,
    ST_DRAIN
  } xbt_state_e;
endpackage

// File: rtl/xbt_beat_bytes.sv
`timescale 1ns/1ps
// Bytes carried by one stream beat: full width, or width minus empty on EOP.
module xbt_beat_bytes #(
  parameter int BEAT_BYTES = 4,
  parameter int EMPTY_W    = 2,
  parameter int OUT_W      = 33
) (
  input  logic               eop_i,
  input  logic [EMPTY_W-1:0] empty_i,
  output logic [OUT_W-1:0]   nbytes_o
);
  localparam logic [OUT_W-1:0] FULL = OUT_W'(BEAT_BYTES);

  always_comb begin
    if (eop_i) nbytes_o = FULL - OUT_W'(empty_i);
    else       nbytes_o = FULL;
  end
endmodule

// File: rtl/xbt_err_sticky.sv
`timescale 1ns/1ps
// Sticky OR accumulator for the error sideband.
module xbt_err_sticky #(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [ERR_W-1:0] err_i,
  output logic [ERR_W-1:0] acc_o
);
  always_ff @(posedge clk) begin
    if (rst || clr_i) acc_o <= '0;
    else if (en_i)    acc_o <= acc_o | err_i;
  end
endmodule

// File: rtl/xbt_record.sv
`timescale 1ns/1ps
// Registered completion record; done is a single-cycle pulse.
module xbt_record #(
  parameter int LEN_W = 32,
  parameter int ERR_W = 8,
  parameter int REC_W = 44
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire_i,
  input  logic [LEN_W-1:0] bytes_i,
  input  logic [ERR_W-1:0] err_i,
  input  logic             early_i,
  output logic [REC_W-1:0] rec_o
);
  localparam int PAD_W = REC_W - LEN_W - ERR_W - 2;

  logic [LEN_W-1:0] bytes_q;
  logic [ERR_W-1:0] err_q;
  logic             early_q;
  logic             done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bytes_q <= '0;
      err_q   <= '0;
      early_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= fire_i;
      if (fire_i) begin
        bytes_q <= bytes_i;
        err_q   <= err_i;
        early_q <= early_i;
      end
    end
  end

  assign rec_o = {done_q, early_q, err_q, {PAD_W{1'b0}}, bytes_q};
endmodule

// File: rtl/xbt_byte_tally.sv
`timescale 1ns/1ps
module xbt_byte_tally
  import xbt_pkg::*;
#(
  parameter int BEAT_BYTES = 4,
  localparam int EMPTY_W = (BEAT_BYTES > 1) ? $clog2(BEAT_BYTES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [LEN_W-1:0]   start_len_i,
  input  logic               start_eop_en_i,
  input  logic               st_valid_i,
  input  logic               st_sop_i,
  input  logic               st_eop_i,
  input  logic [EMPTY_W-1:0] st_empty_i,
  input  logic [ERR_W-1:0]   st_error_i,
  output logic [REC_W-1:0]   rec_o
);
  xbt_state_e       state_q, state_d;
  logic [LEN_W-1:0] len_q;
  logic             eop_en_q;
  logic [LEN_W-1:0] count_q, count_d;
  logic [CNT_W-1:0] nbytes;
  logic [CNT_W-1:0] sum;
  logic             over, reach, zero_done, taking, take_err;
  logic             fire, fin_et;
  logic [LEN_W-1:0] fin_bytes;
  logic [ERR_W-1:0] err_acc, fin_err;

  xbt_beat_bytes #(
    .BEAT_BYTES(BEAT_BYTES),
    .EMPTY_W   (EMPTY_W),
    .OUT_W     (CNT_W)
  ) u_beat (
    .eop_i   (st_eop_i),
    .empty_i (st_empty_i),
    .nbytes_o(nbytes)
  );

  assign sum       = {1'b0, count_q} + nbytes;
  assign over      = sum >  {1'b0, len_q};
  assign reach     = sum >= {1'b0, len_q};
  assign zero_done = (state_q == ST_ARMED) && !eop_en_q && (len_q == '0);
  assign taking    = st_valid_i &&
                     ((state_q == ST_COUNT) || ((state_q == ST_ARMED) && st_sop_i));
  assign take_err  = taking && !zero_done && !start_i;
  assign fin_err   = err_acc | (take_err ? st_error_i : '0);

  xbt_err_sticky #(.ERR_W(ERR_W)) u_err (
    .clk  (clk),
    .rst  (rst),
    .clr_i(start_i),
    .en_i (take_err),
    .err_i(st_error_i),
    .acc_o(err_acc)
  );

  always_comb begin
    state_d   = state_q;
    count_d   = count_q;
    fire      = 1'b0;
    fin_et    = 1'b0;
    fin_bytes = count_q;
    if (start_i) begin
      state_d = ST_ARMED;
      count_d = '0;
    end else begin
      unique case (state_q)
        ST_ARMED, ST_COUNT: begin
          if (zero_done) begin
            fire      = 1'b1;
            fin_bytes = '0;
            state_d   = ST_IDLE;
          end else if (taking) begin
            if (eop_en_q) begin
              if (over) begin
                fire    = 1'b1;
                fin_et  = 1'b1;
                state_d = st_eop_i ? ST_IDLE : ST_DRAIN;
              end else if (st_eop_i) begin
                fire      = 1'b1;
                fin_bytes = sum[LEN_W-1:0];
                state_d   = ST_IDLE;
              end else begin
                count_d = sum[LEN_W-1:0];
                state_d = ST_COUNT;
              end
            end else begin
              if (reach) begin
                fire      = 1'b1;
                fin_bytes = len_q;
                state_d   = ST_IDLE;
              end else begin
                count_d = sum[LEN_W-1:0];
                state_d = ST_COUNT;
              end
            end
          end
        end
        ST_DRAIN: begin
          if (st_valid_i && st_eop_i) state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      count_q  <= '0;
      len_q    <= '0;
      eop_en_q <= 1'b0;
    end else begin
      state_q <= state_d;
      count_q <= count_d;
      if (start_i) begin
        len_q    <= start_len_i;
        eop_en_q <= start_eop_en_i;
      end
    end
  end

  xbt_record #(
    .LEN_W(LEN_W),
    .ERR_W(ERR_W),
    .REC_W(REC_W)
  ) u_rec (
    .clk    (clk),
    .rst    (rst),
    .fire_i (fire),
    .bytes_i(fin_bytes),
    .err_i  (fin_err),
    .early_i(fin_et),
    .rec_o  (rec_o)
  );
endmodule

// File: rtl/xbt_byte_tally_chk.sv
`timescale 1ns/1ps
module xbt_byte_tally_chk
  import xbt_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [LEN_W-1:0] start_len_i,
  input logic             start_eop_en_i,
  input logic [REC_W-1:0] rec_o
);
  logic [LEN_W-1:0] len_sh;
  logic             en_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_sh <= '0;
      en_sh  <= 1'b0;
    end else if (start_i) begin
      len_sh <= start_len_i;
      en_sh  <= start_eop_en_i;
    end
  end

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    rec_o[43] |=> !rec_o[43]);

  p_fields_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !rec_o[43] |-> $stable(rec_o[42:0]));

  p_bytes_le_len_r5: assert property (@(posedge clk) disable iff (rst)
    rec_o[43] |-> (rec_o[31:0] <= len_sh));

  p_len_only_exact_r7: assert property (@(posedge clk) disable iff (rst)
    (rec_o[43] && !en_sh) |-> ((rec_o[31:0] == len_sh) && !rec_o[42]));

  p_start_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    start_i |=> !rec_o[43]);
endmodule

bind xbt_byte_tally xbt_byte_tally_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .start_i       (start_i),
  .start_len_i   (start_len_i),
  .start_eop_en_i(start_eop_en_i),
  .rec_o         (rec_o)
);

// File: tb/xbt_byte_tally_bench.sv
`timescale 1ns/1ps
module xbt_byte_tally_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] start_len_i = '0;
  logic        start_eop_en_i = 1'b0;
  logic        st_valid_i = 1'b0;
  logic        st_sop_i = 1'b0;
  logic        st_eop_i = 1'b0;
  logic [1:0]  st_empty_i = '0;
  logic [7:0]  st_error_i = '0;
  logic [43:0] rec_o;

  int n_chk = 0;
  int n_bad = 0;
  int ndone = 0;
  logic [43:0] cap = '0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  xbt_byte_tally u_xbt_byte_tally (
    .clk(clk), .rst(rst), .start_i(start_i), .start_len_i(start_len_i),
    .start_eop_en_i(start_eop_en_i), .st_valid_i(st_valid_i), .st_sop_i(st_sop_i),
    .st_eop_i(st_eop_i), .st_empty_i(st_empty_i), .st_error_i(st_error_i),
    .rec_o(rec_o)
  );

  always @(negedge clk) begin
    if (!rst && rec_o[43]) begin
      ndone = ndone + 1;
      cap   = rec_o;
    end
  end

  // fields: len, eop_en, nbeats, last empty, error beat (255 none), error value,
  //         expected bytes, expected errors, expected early termination
  localparam logic [99:0] VEC [8] = '{
    {32'd100,  1'b1, 8'd4,  2'd1, 8'd255, 8'h00, 32'd15, 8'h00, 1'b0},
    {32'd16,   1'b1, 8'd4,  2'd0, 8'd2,   8'h10, 32'd16, 8'h10, 1'b0},
    {32'd10,   1'b1, 8'd5,  2'd2, 8'd2,   8'h04, 32'd8,  8'h04, 1'b1},
    {32'd12,   1'b0, 8'd3,  2'd0, 8'd255, 8'h00, 32'd12, 8'h00, 1'b0},
    {32'd1,    1'b1, 8'd1,  2'd3, 8'd255, 8'h00, 32'd1,  8'h00, 1'b0},
    {32'd0,    1'b1, 8'd1,  2'd3, 8'd0,   8'h08, 32'd0,  8'h08, 1'b1},
    {32'd9,    1'b0, 8'd3,  2'd0, 8'd1,   8'h02, 32'd9,  8'h02, 1'b0},
    {32'd1000, 1'b1, 8'd20, 2'd3, 8'd19,  8'h81, 32'd77, 8'h81, 1'b0}
  };

  task automatic check(input bit ok, input string req, input logic [43:0] act,
                       input logic [43:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    end
  endtask

  task automatic start_xfer(input logic [31:0] len, input logic en);
    start_i = 1'b1; start_len_i = len; start_eop_en_i = en;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic beat(input logic sop, input logic eop, input logic [1:0] emp,
                      input logic [7:0] err);
    st_valid_i = 1'b1; st_sop_i = sop; st_eop_i = eop; st_empty_i = emp; st_error_i = err;
    @(negedge clk);
    st_valid_i = 1'b0; st_sop_i = 1'b0; st_eop_i = 1'b0; st_empty_i = '0; st_error_i = '0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
    #1;
  endtask

  task automatic check_rec(input string req, input logic [31:0] xb,
                           input logic [7:0] xe, input logic xet);
    check(ndone == 1, {req, " one record"}, 44'(ndone), 44'd1);
    check(cap[31:0] == xb, {req, " bytes"}, 44'(cap[31:0]), 44'(xb));
    check(cap[41:34] == xe, {req, " errors"}, 44'(cap[41:34]), 44'(xe));
    check(cap[42] == xet, {req, " early"}, 44'(cap[42]), 44'(xet));
    check(cap[33:32] == 2'b00, "R10 pad bits", 44'(cap[33:32]), 44'd0);
    check(!rec_o[43] && rec_o[42:0] == cap[42:0], "R3 hold after done", rec_o, cap);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog all-reqs actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(rec_o == '0, "R1 during reset", rec_o, '0);
    rst = 1'b0;
    @(negedge clk);
    check(rec_o == '0, "R1 after reset", rec_o, '0);

    for (int v = 0; v < 8; v++) begin
      logic [99:0] t;
      t = VEC[v];
      ndone = 0;
      start_xfer(t[99:68], t[67]);
      for (int i = 0; i < int'(t[66:59]); i++) begin
        logic last;
        last = (i == int'(t[66:59]) - 1);
        beat(i == 0, last, last ? t[58:57] : 2'd0, (i == int'(t[56:49])) ? t[48:41] : 8'h00);
      end
      settle();
      check_rec("R2 R4 R5 R7 vector", t[40:9], t[8:1], t[0]);
    end

    // R2: beats before SOP and their errors are ignored
    ndone = 0;
    start_xfer(32'd100, 1'b1);
    beat(1'b0, 1'b0, 2'd0, 8'h40);
    beat(1'b0, 1'b0, 2'd0, 8'h00);
    beat(1'b1, 1'b1, 2'd2, 8'h00);
    settle();
    check_rec("R2 pre-SOP", 32'd2, 8'h00, 1'b0);

    // R4: errors on several beats accumulate
    ndone = 0;
    start_xfer(32'd100, 1'b1);
    beat(1'b1, 1'b0, 2'd0, 8'h01);
    beat(1'b0, 1'b0, 2'd0, 8'h20);
    beat(1'b0, 1'b1, 2'd0, 8'h01);
    settle();
    check_rec("R4 sticky", 32'd12, 8'h21, 1'b0);

    // R5 R6: cutoff mid-packet, then drained beats and a beat with no start
    ndone = 0;
    start_xfer(32'd6, 1'b1);
    beat(1'b1, 1'b0, 2'd0, 8'h00);
    beat(1'b0, 1'b0, 2'd0, 8'h00);
    beat(1'b0, 1'b0, 2'd0, 8'h80);
    beat(1'b0, 1'b1, 2'd0, 8'h00);
    beat(1'b1, 1'b1, 2'd0, 8'h00);
    settle();
    check_rec("R5 R6 drain", 32'd4, 8'h00, 1'b1);

    // R7: EOP does not close a length-only transfer
    ndone = 0;
    start_xfer(32'd12, 1'b0);
    beat(1'b1, 1'b0, 2'd0, 8'h00);
    beat(1'b0, 1'b1, 2'd0, 8'h00);
    #1;
    check(ndone == 0, "R7 no close on EOP", 44'(ndone), 44'd0);
    beat(1'b0, 1'b0, 2'd0, 8'h00);
    settle();
    check_rec("R7 length-only", 32'd12, 8'h00, 1'b0);

    // R8: zero length in length-only mode
    ndone = 0;
    start_xfer(32'd0, 1'b0);
    @(negedge clk);
    #1;
    check(ndone == 1 && rec_o[43], "R8 done timing", rec_o, 44'h800_0000_0000);
    settle();
    check_rec("R8 zero length", 32'd0, 8'h00, 1'b0);

    // R9: restart mid-transfer with a beat in the start cycle
    ndone = 0;
    start_xfer(32'd100, 1'b1);
    beat(1'b1, 1'b0, 2'd0, 8'h40);
    beat(1'b0, 1'b0, 2'd0, 8'h00);
    start_i = 1'b1; start_len_i = 32'd100; start_eop_en_i = 1'b1;
    beat(1'b1, 1'b1, 2'd0, 8'h08);
    start_i = 1'b0;
    beat(1'b1, 1'b0, 2'd0, 8'h00);
    beat(1'b0, 1'b1, 2'd0, 8'h00);
    settle();
    check_rec("R9 restart", 32'd8, 8'h00, 1'b0);

    summary();
    $finish;
  end
endmodule